// File: doc/BRIEF.md
# Bang-Bang Digital Frequency Loop Controller

This block is the digital control loop of an all-digital clock multiplier. It counts cycles of the oscillator-domain clock to make a divided edge once every N cycles. It compares that divided edge with a reference edge, which arrives already synchronised as a one-cycle pulse. It then steers two codes: a coarse code that selects the oscillator's base setting, and a fine word that a pulse-density modulator outside this block turns into a mix of the two neighbouring oscillator settings.

The comparison measures no phase error. At each reference edge the loop only decides whether the divided clock is ahead or behind, and moves the fine word one step in the correcting direction. Because of this the loop always hunts around the target. If two reference edges arrive with no divided edge between them, or two divided edges with no reference edge between them, the frequency is badly off, and the fine word moves by two. When the fine word runs off either end, it is put back to its midpoint and the coarse code moves one step. A freeze input holds the whole loop state for as long as it is high. A lock flag reports a run of strictly alternating decisions.

Top module: `bbfl_ctrl`

## Requirements
- R1: A divider position runs 0..Neff-1 and advances by one on every clock that is not frozen. Neff is `div_n`, or 2 when `div_n` is below 2. A divided edge happens in the cycle where the position is Neff-1, and the position then returns to 0.
- R2: A reference edge that is not a frequency event (R3) is a phase decision. If the divider position is below Neff/2 (integer division), the divided clock leads and `fine_word` falls by 1. Otherwise it lags and `fine_word` rises by 1. A divided edge in the same cycle counts as having arrived, at position Neff-1.
- R3: A reference edge that follows an earlier reference edge with no divided edge since (including the same cycle) raises `fine_word` by 2.
- R4: A divided edge with no reference edge in the same cycle, which follows an earlier divided edge with no reference edge since, lowers `fine_word` by 2.
- R5: If a step would take `fine_word` above 2^FW-1, it is set to the midpoint 2^(FW-1) and `coarse_code` rises by 1. If a step would take it below 0, it is set to the midpoint and `coarse_code` falls by 1. `coarse_code` changes in no other case.
- R6: `coarse_code` saturates at 0 and at 2^CW-1.
- R7: While `freeze` is high, the divider, the edge memory, both codes and the lock state hold, and reference edges are ignored. After release, the loop continues from the held values.
- R8: A synchronous active-low reset loads `coarse_code` from `start_code`, sets `fine_word` to the midpoint, clears `locked`, puts the divider at position 0 and forgets all past edges.
- R9: `locked` is high when the last 8 phase decisions strictly alternated in direction. A decision in the same direction as the one before restarts the run at one. Any frequency step (R3, R4) clears the run.
- R10: Every update takes effect at the clock edge that samples the event, and the outputs show it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse per reference edge, already synchronised |
| div_n | input | NW | Division ratio N (values below 2 act as 2) |
| freeze | input | 1 | Hold all loop state while high |
| start_code | input | CW | Coarse code loaded at reset |
| coarse_code | output | CW | Base oscillator setting |
| fine_word | output | FW | Density word for the pulse modulator |
| locked | output | 1 | Last 8 phase decisions alternated |

## Verification
A wrong divider position or a wrong edge memory shows at the ports at the next reference or divided edge. It appears as a fine step of the wrong sign or size, or as a plus-two or minus-two step where a plus-one or minus-one step belongs. A fault in the wrap logic shows as a coarse step that comes without the fine word returning to its midpoint, or as a coarse code that passes a saturation limit. The bench models the loop arithmetically from the requirements and compares all three outputs in every cycle. The first divergence is therefore reported in the cycle it appears.

// File: rtl/bbfl_pkg.sv
// Shared types of the bang-bang frequency loop.
// Assumes: steps are at most two fine units in either direction.
package bbfl_pkg;

    typedef enum logic [2:0] {
        STEP_NONE = 3'd0,
        STEP_UP1  = 3'd1,
        STEP_DN1  = 3'd2,
        STEP_UP2  = 3'd3,
        STEP_DN2  = 3'd4
    } step_e;

    // Signed fine-word change for a step.
    function automatic logic signed [2:0] step_delta(input step_e s);
        case (s)
            STEP_UP1: return 3'sd1;
            STEP_DN1: return -3'sd1;
            STEP_UP2: return 3'sd2;
            STEP_DN2: return -3'sd2;
            default:  return 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/bbfl_divider.sv
// Divide-by-N counter in the oscillator domain.
// Makes a one-cycle divided edge every Neff unfrozen cycles. Reports whether
// the current position lies in the late half of the period.
// Assumes: div_n below 2 means 2. A div_n that shrinks below the current
// position wraps at the next cycle.
module bbfl_divider #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [NW-1:0] div_n,
    output logic          div_tick,
    output logic          late
);
    logic [NW-1:0] pos;
    logic [NW-1:0] n_eff;

    // Clamp the ratio and decode the edge and the half period.
    always_comb begin
        n_eff    = (div_n < NW'(2)) ? NW'(2) : div_n;
        div_tick = !hold && (pos >= n_eff - NW'(1));
        late     = (pos >= (n_eff >> 1));
    end

    // Position counter, held while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (!hold)
            pos <= div_tick ? '0 : pos + NW'(1);
    end

    assert_div_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> (pos == '0));

    assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(pos));

endmodule

// File: rtl/bbfl_slip_detect.sv
// Direction-only slip detector and lock monitor.
// Decides one step per event:
//   phase step +/-1 on each reference edge,
//   frequency step +2 on a second reference edge with no divided edge since,
//   frequency step -2 on a second divided edge with no reference edge since.
// Tracks the run of alternating phase decisions for the lock flag.
// Assumes: ref_edge is a synchronous one-cycle pulse, and div_tick is already
// gated by hold.
module bbfl_slip_detect
    import bbfl_pkg::*;
#(
    parameter int LOCK_RUN = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  ref_edge,
    input  logic  div_tick,
    input  logic  late,
    output step_e step,
    output logic  locked
);
    localparam int RW = $clog2(LOCK_RUN + 1);

    logic          seen_ref;
    logic          seen_div;
    logic          prev_late;
    logic [RW-1:0] run;
    logic          phase_evt;
    logic          freq_evt;

    // Classify the current cycle's events into one step.
    always_comb begin
        step      = STEP_NONE;
        phase_evt = 1'b0;
        if (!hold && ref_edge) begin
            if (seen_ref && !seen_div && !div_tick) begin
                step = STEP_UP2;
            end else begin
                step      = late ? STEP_UP1 : STEP_DN1;
                phase_evt = 1'b1;
            end
        end else if (div_tick && seen_div && !seen_ref) begin
            step = STEP_DN2;
        end
        freq_evt = (step == STEP_UP2) || (step == STEP_DN2);
    end

    // Remember which edges arrived since the other kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_ref <= 1'b0;
            seen_div <= 1'b0;
        end else if (!hold) begin
            seen_ref <= ref_edge ? 1'b1 : (div_tick ? 1'b0 : seen_ref);
            seen_div <= div_tick ? 1'b1 : (ref_edge ? 1'b0 : seen_div);
        end
    end

    // Count the run of strictly alternating phase decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= '0;
            prev_late <= 1'b0;
        end else if (!hold) begin
            if (freq_evt) begin
                run <= '0;
            end else if (phase_evt) begin
                prev_late <= late;
                if (run == '0 || late == prev_late)
                    run <= RW'(1);
                else if (run != RW'(LOCK_RUN))
                    run <= run + RW'(1);
            end
        end
    end

    assign locked = (run == RW'(LOCK_RUN));

    assert_freq_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        freq_evt |=> !locked);

    assert_same_dir_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_evt && run != '0 && late == prev_late) |=> !locked);

    assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(run) && $stable(seen_ref) && $stable(seen_div)));

endmodule

// File: rtl/bbfl_updown.sv
// Fine and coarse up/down counters.
// The fine word takes each step. If it runs past either end, it returns to
// its midpoint and the coarse code moves one step, saturating at its limits.
// Assumes: step is STEP_NONE while the loop is frozen.
module bbfl_updown
    import bbfl_pkg::*;
#(
    parameter int FW = 6,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_e         step,
    input  logic [CW-1:0] start_code,
    output logic [FW-1:0] fine,
    output logic [CW-1:0] coarse
);
    localparam logic [FW-1:0] FMID = FW'(1) << (FW - 1);
    localparam logic [FW-1:0] FMAX = '1;
    localparam logic [CW-1:0] CMAX = '1;

    logic signed [2:0]    delta;
    logic signed [FW+1:0] sum;
    logic                 ovf;
    logic                 unf;

    // Tentative new fine value and the wrap conditions.
    always_comb begin
        delta = step_delta(step);
        sum   = $signed({2'b00, fine}) + {{(FW - 1){delta[2]}}, delta};
        ovf   = sum > $signed({2'b00, FMAX});
        unf   = sum[FW+1];
    end

    // Apply the step, with the carry or borrow into the coarse code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine   <= FMID;
            coarse <= start_code;
        end else if (step != STEP_NONE) begin
            if (ovf) begin
                fine <= FMID;
                if (coarse != CMAX)
                    coarse <= coarse + CW'(1);
            end else if (unf) begin
                fine <= FMID;
                if (coarse != '0)
                    coarse <= coarse - CW'(1);
            end else begin
                fine <= sum[FW-1:0];
            end
        end
    end

    assert_coarse_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coarse) |-> (fine == FMID));

    assert_coarse_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse == CMAX) |=> (coarse >= CMAX - CW'(1)));

    assert_coarse_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse == '0) |=> (coarse <= CW'(1)));

endmodule

// File: rtl/bbfl_ctrl.sv
// Bang-bang digital frequency loop controller (top).
// Divides the oscillator clock by N, detects only the direction of phase
// slips against the reference edge, and steers a fine density word and a
// coarse oscillator code. The whole state holds under freeze.
// Assumes: ref_edge is synchronous to clk and one cycle wide per edge.
module bbfl_ctrl
    import bbfl_pkg::*;
#(
    parameter int NW       = 8,
    parameter int FW       = 6,
    parameter int CW       = 6,
    parameter int LOCK_RUN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_edge,
    input  logic [NW-1:0] div_n,
    input  logic          freeze,
    input  logic [CW-1:0] start_code,
    output logic [CW-1:0] coarse_code,
    output logic [FW-1:0] fine_word,
    output logic          locked
);
    logic  div_tick;
    logic  late;
    step_e step;

    bbfl_divider #(.NW(NW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (freeze),
        .div_n    (div_n),
        .div_tick (div_tick),
        .late     (late)
    );

    bbfl_slip_detect #(.LOCK_RUN(LOCK_RUN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (freeze),
        .ref_edge (ref_edge),
        .div_tick (div_tick),
        .late     (late),
        .step     (step),
        .locked   (locked)
    );

    bbfl_updown #(.FW(FW), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .start_code (start_code),
        .fine       (fine_word),
        .coarse     (coarse_code)
    );

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(coarse_code) && $stable(fine_word) && $stable(locked)));

    assert_no_step_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (step == STEP_NONE));

endmodule

// File: tb/bbfl_ctrl_bench.sv
// Bench for bbfl_ctrl: an arithmetic model written from the requirements is
// compared in every cycle, plus directed checks of the corner cases.
module bbfl_ctrl_bench;
    localparam int NW = 8, FW = 6, CW = 6, LR = 8;
    localparam int MID = 32, FTOP = 63, CTOP = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_edge = 1'b0;
    logic [NW-1:0] div_n = 8'd10;
    logic          freeze = 1'b0;
    logic [CW-1:0] start_code = 6'd32;
    logic [CW-1:0] coarse_code;
    logic [FW-1:0] fine_word;
    logic          locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // model state
    int m_pos, m_fine, m_coarse, m_run;
    bit m_sr, m_sd, m_prev;

    bbfl_ctrl #(.NW(NW), .FW(FW), .CW(CW), .LOCK_RUN(LR)) u_bbfl_ctrl (
        .clk, .rst_n, .ref_edge, .div_n, .freeze, .start_code,
        .coarse_code, .fine_word, .locked
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        int ne, delta;
        bit tick, lt, ph, fq;
        if (!rst_n) begin
            m_pos = 0; m_sr = 0; m_sd = 0; m_fine = MID;
            m_coarse = start_code; m_run = 0; m_prev = 0;
        end else if (!freeze) begin
            ne    = (div_n < 2) ? 2 : int'(div_n);
            tick  = (m_pos >= ne - 1);
            lt    = (m_pos >= ne / 2);
            delta = 0; ph = 0; fq = 0;
            if (ref_edge) begin
                if (m_sr && !m_sd && !tick) begin delta = 2; fq = 1; end
                else begin delta = lt ? 1 : -1; ph = 1; end
            end else if (tick && m_sd && !m_sr) begin
                delta = -2; fq = 1;
            end
            if (fq) m_run = 0;
            else if (ph) begin
                if (m_run == 0 || lt == m_prev) m_run = 1;
                else if (m_run < LR) m_run++;
                m_prev = lt;
            end
            if (ref_edge) m_sr = 1; else if (tick) m_sr = 0;
            if (tick) m_sd = 1; else if (ref_edge) m_sd = 0;
            m_fine += delta;
            if (m_fine > FTOP) begin
                m_fine = MID;
                if (m_coarse < CTOP) m_coarse++;
            end else if (m_fine < 0) begin
                m_fine = MID;
                if (m_coarse > 0) m_coarse--;
            end
            m_pos = tick ? 0 : m_pos + 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R1 R2 R3 R4 R10 fine", int'(fine_word), m_fine);
            check("R5 R6 coarse", int'(coarse_code), m_coarse);
            check("R9 locked", int'(locked), int'(m_run == LR));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset(int start, int n);
        @(negedge clk);
        rst_n = 0; freeze = 0; ref_edge = 0;
        start_code = CW'(start); div_n = NW'(n);
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_pos(int p);
        while (m_pos != p) @(negedge clk);
    endtask

    task automatic pulse_ref();
        ref_edge = 1;
        @(negedge clk);
        ref_edge = 0;
    endtask

    initial begin
        int prev_c;
        // R8: reset state
        do_reset(40, 10);
        check("R8 coarse after reset", int'(coarse_code), 40);
        check("R8 fine after reset", int'(fine_word), MID);
        check("R8 locked after reset", int'(locked), 0);
        cmp_en = 1;

        // R4: N=2 with no reference, the second divided edge gives -2
        do_reset(32, 2);
        repeat (4) @(negedge clk);
        check("R4 first fast step", int'(fine_word), 30);
        repeat (2) @(negedge clk);
        check("R4 second fast step", int'(fine_word), 28);

        // R2 and R3: N=200, early reference then a second one
        do_reset(32, 200);
        repeat (5) @(negedge clk);
        pulse_ref();
        check("R2 lead step", int'(fine_word), 31);
        repeat (3) @(negedge clk);
        pulse_ref();
        check("R3 slow step", int'(fine_word), 33);

        // Sweep ratios (incl. clamped 0 and 1) against reference intervals
        foreach (div_n_list[i]) begin
            for (int d = -2; d <= 2; d++) begin
                int p;
                p = div_n_list[i] + d;
                if (p < 1) p = 1;
                do_reset(32, div_n_list[i]);
                for (int c = 0; c < 300; c++) begin
                    ref_edge = ((c % p) == p - 1) || (d == 2 && (c % 7) == 3);
                    @(negedge clk);
                end
                ref_edge = 0;
            end
        end

        // R7: freeze holds everything while reference edges arrive
        do_reset(32, 6);
        for (int c = 0; c < 40; c++) begin ref_edge = (c % 4 == 0); @(negedge clk); end
        ref_edge = 0;
        freeze = 1;
        @(negedge clk);
        begin
            int sf, sc, sl;
            sf = fine_word; sc = coarse_code; sl = locked;
            for (int c = 0; c < 60; c++) begin ref_edge = (c % 3 == 0); @(negedge clk); end
            ref_edge = 0;
            check("R7 fine held", int'(fine_word), sf);
            check("R7 coarse held", int'(coarse_code), sc);
            check("R7 locked held", int'(locked), sl);
        end
        freeze = 0;
        for (int c = 0; c < 40; c++) begin ref_edge = (c % 5 == 0); @(negedge clk); end
        ref_edge = 0;

        // R5 and R6 upward: frequent reference, huge ratio
        do_reset(60, 200);
        prev_c = coarse_code;
        for (int c = 0; c < 1500; c++) begin
            ref_edge = (c % 3 == 0);
            @(negedge clk);
            if (int'(coarse_code) != prev_c) begin
                check("R5 carry lands fine at midpoint", int'(fine_word), MID);
                check("R5 carry moves coarse by one", int'(coarse_code), prev_c + 1);
                prev_c = coarse_code;
            end
        end
        ref_edge = 0;
        check("R6 coarse saturates high", int'(coarse_code), CTOP);

        // R5 and R6 downward: no reference, ratio 2
        do_reset(3, 2);
        prev_c = coarse_code;
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk);
            if (int'(coarse_code) != prev_c) begin
                check("R5 borrow moves coarse by one", int'(coarse_code), prev_c - 1);
                prev_c = coarse_code;
            end
        end
        check("R6 coarse saturates low", int'(coarse_code), 0);

        // R9: lock after 8 alternating decisions
        do_reset(32, 10);
        for (int k = 1; k <= 8; k++) begin
            wait_pos(0);
            wait_pos((k % 2 == 1) ? 1 : 8);
            pulse_ref();
            if (k == 7) check("R9 not locked after 7", int'(locked), 0);
        end
        check("R9 locked after 8", int'(locked), 1);
        wait_pos(0); wait_pos(8); pulse_ref();
        check("R9 same direction drops lock", int'(locked), 0);
        for (int k = 1; k <= 7; k++) begin
            wait_pos(0);
            wait_pos((k % 2 == 1) ? 1 : 8);
            pulse_ref();
        end
        check("R9 relocked", int'(locked), 1);
        wait_pos(0); wait_pos(1); pulse_ref();
        check("R9 same direction again", int'(locked), 0);
        for (int k = 1; k <= 7; k++) begin
            wait_pos(0);
            wait_pos((k % 2 == 1) ? 8 : 1);
            pulse_ref();
        end
        check("R9 locked before frequency step", int'(locked), 1);
        wait_pos(0); wait_pos(3); pulse_ref(); pulse_ref();
        check("R9 frequency step drops lock", int'(locked), 0);

        cmp_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int div_n_list[7] = '{0, 1, 2, 3, 5, 8, 13};

endmodule